// File: doc/BRIEF.md
# Tagged Capability Memory Controller

This block wraps a small on-chip data memory and gives every capability-sized, capability-aligned word one hidden validity bit. Two kinds of request share one port. Data requests move a byte, a halfword or a word and cannot see or set the hidden bit. Capability requests move a whole double-width word together with its bit. Any data store clears the bit of the word it lands in, in the same clock edge as the data write. A capability store writes the word and the supplied bit together. A capability load returns both.

The address space is split into equal regions, selected by the top address bits. A small register bank, written through a configuration port, marks each region as tagged or untagged. A capability stored into an untagged region loses its bit. A capability loaded from an untagged region always comes back with the bit low. Requests are accepted every cycle, and the response appears one cycle later.

Top module: `tagmem_ctrl`

## Requirements
- R1: After reset, every word reads as zero, every validity bit is clear, every region is tagged, and rsp_valid, rsp_rdata, rsp_tag and rsp_align_err are low.
- R2: Every request accepted in cycle N gives rsp_valid high in cycle N+1. A cycle without a request gives rsp_valid low with rsp_rdata, rsp_tag and rsp_align_err at zero.
- R3: req_size codes are 0 for byte, 1 for halfword, 2 for word and 3 for capability. A data store writes its 1, 2 or 4 low bytes of req_wdata starting at byte offset req_addr[2:0] rounded down to the access size, with the least significant byte at the lowest offset. All other bytes of the word keep their values.
- R4: A data store of any size clears the validity bit of the capability word it touches.
- R5: A capability store with an aligned address, into a tagged region, writes all 64 data bits and the supplied bit. A capability load returns the stored data and the stored bit.
- R6: A data load returns the selected bytes zero-extended in rsp_rdata, and rsp_tag stays low even when the word's bit is set.
- R7: A capability stored into a region marked untagged is stored with its bit clear. A capability loaded from a region that is currently untagged returns rsp_tag low. The region is req_addr[6:5] at the default sizes.
- R8: A capability request whose address is not a multiple of 8 sets rsp_align_err, returns zero data and a clear bit, and changes neither memory nor bits.
- R9: Copying a capability by loading it and then storing the returned data and bit preserves the bit, whether it is set or clear.
- R10: A configuration write takes effect from the next cycle. A request in the same cycle as the configuration write sees the region's previous setting.
- R11: Loads leave the memory contents and the validity bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A request is presented this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 capability |
| req_addr | input | 7 | Byte address |
| req_wdata | input | 64 | Store data, low bytes used by data stores |
| req_wtag | input | 1 | Validity bit for a capability store |
| cfg_we | input | 1 | Write one region setting |
| cfg_region | input | 2 | Region selected by the configuration write |
| cfg_untagged | input | 1 | 1 marks the region untagged |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_rdata | output | 64 | Load data, zero for stores and errors |
| rsp_tag | output | 1 | Validity bit from a capability load |
| rsp_align_err | output | 1 | Misaligned capability request |

## Verification
A configuration write and a capability access to the same region can fall in the same cycle. Which region setting that access obeys is the point where the design is most likely to go wrong. The bench provokes this on purpose: it stores a capability with its bit set in the very cycle its region turns untagged. The store must keep the bit, because it used the old setting. The load that follows must return it clear, and after the region is tagged again the load must return it set. Random traffic with configuration writes mixed in repeats the collision many times, and the bench's behavioural model judges every response cycle by cycle.

// File: rtl/tagmem_pkg.sv
`timescale 1ns/1ps
package tagmem_pkg;
  parameter int unsigned XLEN = 32;
  localparam int unsigned CAP_W = 2 * XLEN;
  localparam int unsigned CAP_BYTES = CAP_W / 8;
  localparam int unsigned OFF_W = $clog2(CAP_BYTES);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_CAP  = 2'd3
  } acc_size_e;

  function automatic int size_bytes(acc_size_e sz);
    case (sz)
      SZ_BYTE: return 1;
      SZ_HALF: return 2;
      SZ_WORD: return XLEN / 8;
      default: return CAP_BYTES;
    endcase
  endfunction

  function automatic int lane_base(acc_size_e sz, logic [OFF_W-1:0] off);
    int n;
    n = size_bytes(sz);
    return (int'(off) / n) * n;
  endfunction

  function automatic logic [CAP_BYTES-1:0] lane_mask(acc_size_e sz, logic [OFF_W-1:0] off);
    logic [CAP_BYTES-1:0] m;
    int n;
    int b;
    n = size_bytes(sz);
    b = lane_base(sz, off);
    for (int i = 0; i < CAP_BYTES; i++) m[i] = (i >= b) && (i < b + n);
    return m;
  endfunction

  function automatic logic [CAP_W-1:0] spread_wdata(acc_size_e sz, logic [CAP_W-1:0] d);
    logic [CAP_W-1:0] o;
    int n;
    n = size_bytes(sz);
    for (int i = 0; i < CAP_BYTES; i++) o[8*i +: 8] = d[8*(i % n) +: 8];
    return o;
  endfunction

  function automatic logic [CAP_W-1:0] pick_lane(acc_size_e sz, logic [OFF_W-1:0] off,
                                                  logic [CAP_W-1:0] w);
    logic [CAP_W-1:0] o;
    int n;
    int b;
    n = size_bytes(sz);
    b = lane_base(sz, off);
    o = '0;
    for (int i = 0; i < CAP_BYTES; i++) if (i < n) o[8*i +: 8] = w[8*(b+i) +: 8];
    return o;
  endfunction
endpackage

// File: rtl/tm_region_bank.sv
`timescale 1ns/1ps
module tm_region_bank #(
  parameter int unsigned REGIONS = 4,
  localparam int unsigned RB = $clog2(REGIONS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [RB-1:0] cfg_sel,
  input  logic          cfg_val,
  input  logic [RB-1:0] lk_sel,
  output logic          lk_untagged
);
  logic [REGIONS-1:0] untag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) untag_q <= '0;
    else if (cfg_we) untag_q[cfg_sel] <= cfg_val;
  end

  assign lk_untagged = untag_q[lk_sel];

  AST_CFG_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> untag_q[$past(cfg_sel)] == $past(cfg_val)); // R10
endmodule

// File: rtl/tm_tag_array.sv
`timescale 1ns/1ps
module tm_tag_array #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned IW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_en,
  input  logic          clr_en,
  input  logic [IW-1:0] idx,
  input  logic          tag_in,
  output logic          tag_out
);
  logic [DEPTH-1:0] tags_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tags_q <= '0;
    else if (set_en) tags_q[idx] <= tag_in;
    else if (clr_en) tags_q[idx] <= 1'b0;
  end

  assign tag_out = tags_q[idx];

  AST_DATA_STORE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> !tags_q[$past(idx)]); // R4
  AST_CAP_STORE_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> tags_q[$past(idx)] == $past(tag_in)); // R5
  AST_TAGS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_en || clr_en) |=> $stable(tags_q)); // R11
  AST_ONE_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_en && clr_en)); // R4
endmodule

// File: rtl/tm_data_array.sv
`timescale 1ns/1ps
module tm_data_array #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned NBYTES = 8,
  localparam int unsigned IW = $clog2(DEPTH),
  localparam int unsigned DW = 8 * NBYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IW-1:0]     idx,
  input  logic [NBYTES-1:0] be,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata
);
  logic [DW-1:0] mem_q [DEPTH];

  for (genvar g = 0; g < NBYTES; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int e = 0; e < DEPTH; e++) mem_q[e][8*g +: 8] <= '0;
      end else if (we && be[g]) begin
        mem_q[idx][8*g +: 8] <= wdata[8*g +: 8];
      end
    end
  end

  assign rdata = mem_q[idx];

  AST_NO_WRITE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!we && $past(rst_n)) |=> mem_q[$past(idx)] == $past(rdata)); // R11
endmodule

// File: rtl/tagmem_ctrl.sv
`timescale 1ns/1ps
module tagmem_ctrl
  import tagmem_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned REGIONS = 4,
  localparam int unsigned IW = $clog2(DEPTH),
  localparam int unsigned AW = IW + OFF_W,
  localparam int unsigned RB = $clog2(REGIONS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [1:0]       req_size,
  input  logic [AW-1:0]    req_addr,
  input  logic [CAP_W-1:0] req_wdata,
  input  logic             req_wtag,
  input  logic             cfg_we,
  input  logic [RB-1:0]    cfg_region,
  input  logic             cfg_untagged,
  output logic             rsp_valid,
  output logic [CAP_W-1:0] rsp_rdata,
  output logic             rsp_tag,
  output logic             rsp_align_err
);
  acc_size_e        sz;
  logic [OFF_W-1:0] off;
  logic [IW-1:0]    idx;
  logic [RB-1:0]    region;
  logic             is_cap, misaligned, reg_untag;
  logic             ev_cap_wr, ev_data_wr, ev_cap_rd, ev_rd, ev_align_err;
  logic [CAP_W-1:0] rd_word;
  logic             rd_tag;
  logic             rsp_cap_q;

  assign sz         = acc_size_e'(req_size);
  assign off        = req_addr[OFF_W-1:0];
  assign idx        = req_addr[AW-1:OFF_W];
  assign region     = req_addr[AW-1 -: RB];
  assign is_cap     = (sz == SZ_CAP);
  assign misaligned = is_cap && (off != '0);

  assign ev_cap_wr    = req_valid && req_write && is_cap && !misaligned;
  assign ev_data_wr   = req_valid && req_write && !is_cap;
  assign ev_rd        = req_valid && !req_write && !misaligned;
  assign ev_cap_rd    = ev_rd && is_cap;
  assign ev_align_err = req_valid && misaligned;

  tm_region_bank #(.REGIONS(REGIONS)) u_regions (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_region),
    .cfg_val(cfg_untagged), .lk_sel(region), .lk_untagged(reg_untag));

  tm_data_array #(.DEPTH(DEPTH), .NBYTES(CAP_BYTES)) u_data (
    .clk(clk), .rst_n(rst_n), .we(ev_cap_wr || ev_data_wr), .idx(idx),
    .be(lane_mask(sz, off)), .wdata(spread_wdata(sz, req_wdata)), .rdata(rd_word));

  tm_tag_array #(.DEPTH(DEPTH)) u_tags (
    .clk(clk), .rst_n(rst_n), .set_en(ev_cap_wr), .clr_en(ev_data_wr), .idx(idx),
    .tag_in(req_wtag && !reg_untag), .tag_out(rd_tag));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid     <= 1'b0;
      rsp_rdata     <= '0;
      rsp_tag       <= 1'b0;
      rsp_align_err <= 1'b0;
      rsp_cap_q     <= 1'b0;
    end else begin
      rsp_valid     <= req_valid;
      rsp_rdata     <= ev_rd ? pick_lane(sz, off, rd_word) : '0;
      rsp_tag       <= ev_cap_rd && rd_tag && !reg_untag;
      rsp_align_err <= ev_align_err;
      rsp_cap_q     <= ev_cap_rd;
    end
  end

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (rsp_rdata == '0) && !rsp_tag && !rsp_align_err); // R2
  AST_DATA_NO_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_cap_q |-> !rsp_tag); // R6
  AST_UNTAGGED_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_cap_rd && reg_untag) |=> !rsp_tag); // R7
  AST_MISALIGNED_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    ev_align_err |=> rsp_align_err && (rsp_rdata == '0) && !rsp_tag); // R8
endmodule

// File: tb/sim_tagmem_ctrl.sv
`timescale 1ns/1ps
module sim_tagmem_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_wtag = 1'b0;
  logic [1:0]  req_size = 2'd0;
  logic [6:0]  req_addr = '0;
  logic [63:0] req_wdata = '0;
  logic        cfg_we = 1'b0, cfg_untagged = 1'b0;
  logic [1:0]  cfg_region = '0;
  logic        rsp_valid, rsp_tag, rsp_align_err;
  logic [63:0] rsp_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [63:0] m_mem [16];
  bit          m_tag [16];
  bit          m_unt [4];

  always #10 clk = ~clk;

  tagmem_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata), .req_wtag(req_wtag),
    .cfg_we(cfg_we), .cfg_region(cfg_region), .cfg_untagged(cfg_untagged),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_tag(rsp_tag),
    .rsp_align_err(rsp_align_err));

  task automatic compare(string rq, bit ev, bit et, bit ee, logic [63:0] ed);
    checks++;
    if (rsp_valid !== ev || rsp_tag !== et || rsp_align_err !== ee || rsp_rdata !== ed) begin
      errors++;
      $display("FAIL %s: got v=%0b tag=%0b err=%0b data=%h, expected v=%0b tag=%0b err=%0b data=%h",
               rq, rsp_valid, rsp_tag, rsp_align_err, rsp_rdata, ev, et, ee, ed);
    end
  endtask

  // One clock of stimulus; the model predicts the response and is then updated.
  task automatic op(string rq, bit v, bit wr, logic [1:0] sz, logic [6:0] a,
                    logic [63:0] wd, bit wt, bit cwe, logic [1:0] creg, bit cval);
    bit e_t, e_e;
    logic [63:0] e_d;
    int w, o, n, b, rg;
    @(negedge clk);
    req_valid = v; req_write = wr; req_size = sz; req_addr = a;
    req_wdata = wd; req_wtag = wt; cfg_we = cwe; cfg_region = creg; cfg_untagged = cval;
    e_t = 0; e_e = 0; e_d = '0;
    if (v) begin
      w = int'(a[6:3]); o = int'(a[2:0]); rg = int'(a[6:5]);
      n = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : (sz == 2'd2) ? 4 : 8;
      b = o - (o % n);
      if (sz == 2'd3 && o != 0) e_e = 1;
      else if (!wr) begin
        for (int i = 0; i < n; i++) e_d[8*i +: 8] = m_mem[w][8*(b+i) +: 8];
        if (sz == 2'd3) e_t = m_tag[w] && !m_unt[rg];
      end else begin
        for (int i = 0; i < n; i++) m_mem[w][8*(b+i) +: 8] = wd[8*i +: 8];
        m_tag[w] = (sz == 2'd3) ? (wt && !m_unt[rg]) : 1'b0;
      end
    end
    if (cwe) m_unt[int'(creg)] = cval;
    @(posedge clk);
    #2;
    compare(rq, v, e_t, e_e, e_d);
  endtask

  task automatic capld(string rq, logic [6:0] a);
    op(rq, 1, 0, 2'd3, a, '0, 0, 0, 2'd0, 0);
  endtask
  task automatic capst(string rq, logic [6:0] a, logic [63:0] d, bit t);
    op(rq, 1, 1, 2'd3, a, d, t, 0, 2'd0, 0);
  endtask
  task automatic cfgw(string rq, logic [1:0] r, bit u);
    op(rq, 0, 0, 2'd0, '0, '0, 0, 1, r, u);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog (R2): got no completion after 200000 cycles, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] cpy_d;
    bit cpy_t;
    for (int i = 0; i < 16; i++) begin m_mem[i] = '0; m_tag[i] = 0; end
    for (int i = 0; i < 4; i++) m_unt[i] = 0;
    repeat (3) @(posedge clk);
    #2;
    compare("R1 outputs in reset", 0, 0, 0, '0);
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < 16; i++) capld("R1 word after reset", 7'(i * 8));
    op("R2 idle cycle", 0, 0, 2'd0, '0, '0, 0, 0, 2'd0, 0);

    // R5: capability store and load, tag set
    capst("R5 cap store", 7'd24, 64'h1122_3344_5566_7788, 1);
    capld("R5 cap load", 7'd24);
    // R4/R3: byte store into tagged word clears tag, merges lane
    op("R4 byte store", 1, 1, 2'd0, 7'd29, 64'hFFFF_FFFF_FFFF_FFA5, 0, 0, 2'd0, 0);
    capld("R4 tag cleared by byte store", 7'd24);
    capst("R4 re-tag", 7'd24, 64'hDEAD_BEEF_0BAD_F00D, 1);
    op("R4 half store", 1, 1, 2'd1, 7'd27, 64'h0000_0000_0000_C3C3, 0, 0, 2'd0, 0);
    capld("R4 tag cleared by half store", 7'd24);
    capst("R4 re-tag", 7'd24, 64'h0123_4567_89AB_CDEF, 1);
    op("R4 word store", 1, 1, 2'd2, 7'd28, 64'h0000_0000_CAFE_D00D, 0, 0, 2'd0, 0);
    capld("R3 word lanes merged", 7'd24);
    // R6: data loads on a tagged word
    capst("R6 tag word", 7'd16, 64'h8877_6655_4433_2211, 1);
    op("R6 byte load", 1, 0, 2'd0, 7'd21, '0, 0, 0, 2'd0, 0);
    op("R6 half load", 1, 0, 2'd1, 7'd19, '0, 0, 0, 2'd0, 0);
    op("R6 word load", 1, 0, 2'd2, 7'd20, '0, 0, 0, 2'd0, 0);
    capld("R11 loads left tag", 7'd16);
    // R8: misaligned capability store and load
    op("R8 misaligned store", 1, 1, 2'd3, 7'd19, 64'hFFFF_FFFF_FFFF_FFFF, 1, 0, 2'd0, 0);
    op("R8 misaligned load", 1, 0, 2'd3, 7'd20, '0, 0, 0, 2'd0, 0);
    capld("R8 memory untouched", 7'd16);
    // R9: copy with tag set and tag clear
    capld("R9 read source", 7'd16);
    cpy_d = rsp_rdata; cpy_t = rsp_tag;
    capst("R9 write copy", 7'd8, cpy_d, cpy_t);
    capld("R9 copy keeps set tag", 7'd8);
    capld("R9 read untagged source", 7'd24);
    cpy_d = rsp_rdata; cpy_t = rsp_tag;
    capst("R9 write copy", 7'd0, cpy_d, cpy_t);
    capld("R9 copy keeps clear tag", 7'd0);
    // R7: untagged region 1 (words 4..7)
    capst("R7 pre-store tagged", 7'd32, 64'hAAAA_5555_AAAA_5555, 1);
    cfgw("R7 mark region untagged", 2'd1, 1);
    capld("R7 load masked", 7'd32);
    capst("R7 store drops tag", 7'd40, 64'h1234_5678_9ABC_DEF0, 1);
    cfgw("R7 mark region tagged", 2'd1, 0);
    capld("R7 dropped tag stays clear", 7'd40);
    capld("R7 earlier tag visible again", 7'd32);
    // R10: configuration write in the same cycle as a capability store
    op("R10 store with same-cycle cfg", 1, 1, 2'd3, 7'd64, 64'h0F0F_F0F0_0F0F_F0F0, 1, 1, 2'd2, 1);
    capld("R10 region now untagged", 7'd64);
    op("R10 load with same-cycle cfg", 1, 0, 2'd3, 7'd64, '0, 0, 1, 2'd2, 0);
    capld("R10 region tagged again", 7'd64);

    // random traffic against the model
    for (int k = 0; k < 600; k++) begin
      logic [1:0] s;
      logic [6:0] a;
      s = 2'($urandom % 4);
      a = 7'($urandom);
      if (s == 2'd3 && ($urandom % 4) != 0) a[2:0] = 3'd0;
      op("R2 random traffic", ($urandom % 8) != 0, $urandom % 2, s, a,
         {$urandom, $urandom}, $urandom % 2, ($urandom % 8) == 0,
         2'($urandom % 4), $urandom % 2);
    end
    for (int i = 0; i < 16; i++) capld("R11 final sweep", 7'(i * 8));

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule